// File: doc/BRIEF.md
# Shared Bias and Tracking Power Controller

This block controls one bias circuit and one tracking circuit that three USB2 pad clients share. Clients ask for the shared resource with a one-cycle enable request and give it back with a one-cycle disable request. The block keeps a 2-bit use count of how many clients currently hold the resource.

Only two kinds of request start a hardware sequence:

- **Power-up.** An enable that takes the count from zero to one turns on the tracking clock, loads the two tracking timer fields, and releases bias power-down while it captures the squelch level. After a settle interval it releases tracking power-down.
- **Power-down.** A disable that takes the count from one to zero sets tracking power-down again and then turns off the tracking clock.

Every other accepted request only moves the count. A disable at zero is flagged as an underflow.

While a sequence runs, `busy` is high and every request is dropped, so a client must retry once `busy` falls.

Top module: `bias_track_ctrl`

## Requirements
- R1: After reset: `use_count` is 0, `busy` and `underflow` are 0, `trk_clk_en` is 0, `bias_pd` and `trk_pd` are 1, and `squelch_lvl`, `start_timer` and `done_timer` are 0.
- R2: An enable accepted with the count at 0 works through these clock edges:
  - On the accepting edge, `trk_clk_en` goes to 1, `use_count` goes to 1 and `busy` goes to 1.
  - On the next edge, `start_timer` loads 0x1E and `done_timer` loads 0x0A.
  - On the edge after that, `bias_pd` goes to 0 and `squelch_lvl` takes `squelch_in`.
- R3: `trk_pd` goes to 0 exactly SETTLE_CYCLES clock edges after the edge that cleared `bias_pd`, and `busy` falls on that same edge. The default of 250 cycles at 250 MHz gives 1 µs.
- R4: An enable accepted with the count at 1 or 2 increments the count and nothing else. With the count at 3, an enable leaves the count at 3. Neither case raises `busy` or changes any pad control output.
- R5: A disable accepted with the count at 2 or 3 decrements the count and changes no pad control output.
- R6: A disable accepted with the count at 1 works through these clock edges:
  - On the accepting edge, `use_count` goes to 0, `trk_pd` goes to 1 and `busy` goes to 1.
  - On the next edge, `trk_clk_en` goes to 0 and `busy` goes to 0.
  - `bias_pd` stays at 0 throughout.
- R7: A disable with the count at 0 raises `underflow` for exactly one cycle and leaves the count at 0.
- R8: Requests that arrive while `busy` is 1 are ignored.
- R9: An enable and a disable in the same cycle are ignored.
- R10: `squelch_lvl` changes only during a power-up. Later changes on `squelch_in` do not reach it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_req | input | 1 | One-cycle request to take a reference |
| dis_req | input | 1 | One-cycle request to drop a reference |
| squelch_in | input | 3 | Squelch level applied at power-up |
| busy | output | 1 | A power sequence is running; requests are dropped |
| use_count | output | 2 | Current number of holders |
| underflow | output | 1 | One-cycle flag for a disable at count zero |
| trk_clk_en | output | 1 | Tracking clock enable |
| bias_pd | output | 1 | Bias power-down control |
| trk_pd | output | 1 | Tracking power-down control |
| squelch_lvl | output | 3 | Applied squelch level |
| start_timer | output | 7 | Tracking start timer field |
| done_timer | output | 7 | Tracking done-reset timer field |

## Verification
A count that is off by one shows at the ports in the cycle the request is accepted. It also shows later, on the disable that should or should not have powered the circuit down: `trk_pd` and `trk_clk_en` end up disagreeing with the number of holders. A wrong sequencing state shows as `busy` held for the wrong number of cycles, or as `trk_pd` being released while `bias_pd` or the clock is still off. The checker catches that ordering error on the edge where it happens. The bench drives every count value with enable, disable and combined requests at each of eight squelch settings. It compares each result against an arithmetic model in the cycle after the request.

// File: rtl/bias_track_ctrl.sv
module bias_track_ctrl #(
  parameter int SETTLE_CYCLES = 250,
  parameter logic [6:0] START_TIMER_VAL = 7'h1E,
  parameter logic [6:0] DONE_TIMER_VAL = 7'h0A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_req,
  input  logic       dis_req,
  input  logic [2:0] squelch_in,
  output logic       busy,
  output logic [1:0] use_count,
  output logic       underflow,
  output logic       trk_clk_en,
  output logic       bias_pd,
  output logic       trk_pd,
  output logic [2:0] squelch_lvl,
  output logic [6:0] start_timer,
  output logic [6:0] done_timer
);
  localparam int WW = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [WW-1:0] WAIT_LAST = WW'(SETTLE_CYCLES - 1);

  typedef enum logic [2:0] {S_IDLE, S_TIMERS, S_BIAS, S_WAIT, S_CLKOFF} state_t;
  state_t state;
  logic [WW-1:0] wait_cnt;

  wire do_en  = (state == S_IDLE) && en_req && !dis_req;
  wire do_dis = (state == S_IDLE) && dis_req && !en_req;

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      wait_cnt    <= '0;
      use_count   <= 2'd0;
      underflow   <= 1'b0;
      trk_clk_en  <= 1'b0;
      bias_pd     <= 1'b1;
      trk_pd      <= 1'b1;
      squelch_lvl <= 3'd0;
      start_timer <= 7'd0;
      done_timer  <= 7'd0;
    end else begin
      underflow <= 1'b0;
      case (state)
        S_IDLE: begin
          if (do_en) begin
            if (use_count == 2'd0) begin
              trk_clk_en <= 1'b1;
              state      <= S_TIMERS;
            end
            if (use_count != 2'd3) use_count <= use_count + 2'd1;
          end else if (do_dis) begin
            if (use_count == 2'd0) begin
              underflow <= 1'b1;
            end else begin
              use_count <= use_count - 2'd1;
              if (use_count == 2'd1) begin
                trk_pd <= 1'b1;
                state  <= S_CLKOFF;
              end
            end
          end
        end
        S_TIMERS: begin
          start_timer <= START_TIMER_VAL;
          done_timer  <= DONE_TIMER_VAL;
          state       <= S_BIAS;
        end
        S_BIAS: begin
          bias_pd     <= 1'b0;
          squelch_lvl <= squelch_in;
          wait_cnt    <= '0;
          state       <= S_WAIT;
        end
        S_WAIT: begin
          if (wait_cnt == WAIT_LAST) begin
            trk_pd <= 1'b0;
            state  <= S_IDLE;
          end else begin
            wait_cnt <= wait_cnt + 1'b1;
          end
        end
        S_CLKOFF: begin
          trk_clk_en <= 1'b0;
          state      <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module bias_track_ctrl_chk #(
  parameter logic [6:0] START_TIMER_VAL = 7'h1E
) (
  input logic       clk,
  input logic       rst_n,
  input logic       en_req,
  input logic       dis_req,
  input logic       busy,
  input logic [1:0] use_count,
  input logic       underflow,
  input logic       trk_clk_en,
  input logic       bias_pd,
  input logic       trk_pd,
  input logic [6:0] start_timer
);
  assert_first_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (use_count == 2'd0 && en_req && !dis_req && !busy) |=> (busy && trk_clk_en && use_count == 2'd1));

  assert_trk_needs_bias_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trk_pd) |-> (!$past(bias_pd) && trk_clk_en && start_timer == START_TIMER_VAL));

  assert_trk_needs_clk_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !trk_pd |-> trk_clk_en);

  assert_saturate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (use_count == 2'd3 && en_req && !dis_req && !busy) |=> (use_count == 2'd3 && !busy));

  assert_clk_off_after_pd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trk_clk_en) |-> (trk_pd && !busy));

  assert_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (use_count == 2'd0 && dis_req && !en_req && !busy) |=> (underflow && use_count == 2'd0));

  assert_busy_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(use_count));

  assert_both_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_req && dis_req && !busy) |=> ($stable(use_count) && !underflow));
endmodule

bind bias_track_ctrl bias_track_ctrl_chk #(.START_TIMER_VAL(START_TIMER_VAL)) chk (
  .clk(clk), .rst_n(rst_n), .en_req(en_req), .dis_req(dis_req), .busy(busy),
  .use_count(use_count), .underflow(underflow), .trk_clk_en(trk_clk_en),
  .bias_pd(bias_pd), .trk_pd(trk_pd), .start_timer(start_timer)
);

// File: tb/bias_track_ctrl_test.sv
module bias_track_ctrl_test;
  localparam int SETTLE = 250;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_req = 1'b0;
  logic dis_req = 1'b0;
  logic [2:0] squelch_in = 3'd0;
  logic busy, underflow, trk_clk_en, bias_pd, trk_pd;
  logic [1:0] use_count;
  logic [2:0] squelch_lvl;
  logic [6:0] start_timer, done_timer;

  int checks = 0;
  int failures = 0;
  int m_cnt = 0;
  bit m_bias_on = 0;
  int m_sq = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bias_track_ctrl #(.SETTLE_CYCLES(SETTLE)) uut (
    .clk(clk), .rst_n(rst_n), .en_req(en_req), .dis_req(dis_req), .squelch_in(squelch_in),
    .busy(busy), .use_count(use_count), .underflow(underflow), .trk_clk_en(trk_clk_en),
    .bias_pd(bias_pd), .trk_pd(trk_pd), .squelch_lvl(squelch_lvl),
    .start_timer(start_timer), .done_timer(done_timer)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic check_static(string req);
    chk(req, "trk_pd", int'(trk_pd), int'(m_cnt == 0));
    chk(req, "trk_clk_en", int'(trk_clk_en), int'(m_cnt != 0));
    chk(req, "bias_pd", int'(bias_pd), int'(!m_bias_on));
    chk(req, "start_timer", int'(start_timer), m_bias_on ? 30 : 0);
    chk(req, "done_timer", int'(done_timer), m_bias_on ? 10 : 0);
    if (m_cnt > 0) chk(req, "squelch_lvl", int'(squelch_lvl), m_sq);
  endtask

  task automatic step(bit e, bit d, string req);
    int exp_busy = 0;
    int exp_uf = 0;
    int n = 0;
    if (e && !d) begin
      if (m_cnt == 0) begin
        exp_busy = 1; m_bias_on = 1; m_sq = int'(squelch_in);
      end
      if (m_cnt < 3) m_cnt++;
    end else if (d && !e) begin
      if (m_cnt == 0) exp_uf = 1;
      else begin
        if (m_cnt == 1) exp_busy = 1;
        m_cnt--;
      end
    end
    en_req = e; dis_req = d;
    @(negedge clk);
    en_req = 0; dis_req = 0;
    chk(req, "use_count", int'(use_count), m_cnt);
    chk(req, "busy", int'(busy), exp_busy);
    chk(req, "underflow", int'(underflow), exp_uf);
    while (busy && n < 1000) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
    chk(req, "underflow_cleared", int'(underflow), 0);
    check_static(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    summary();
  end

  initial begin
    int k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "use_count", int'(use_count), 0);
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "underflow", int'(underflow), 0);
    chk("R1", "trk_clk_en", int'(trk_clk_en), 0);
    chk("R1", "bias_pd", int'(bias_pd), 1);
    chk("R1", "trk_pd", int'(trk_pd), 1);
    chk("R1", "squelch_lvl", int'(squelch_lvl), 0);
    chk("R1", "start_timer", int'(start_timer), 0);
    chk("R1", "done_timer", int'(done_timer), 0);

    // R2 / R3 detailed power-up
    squelch_in = 3'd5;
    en_req = 1;
    @(negedge clk);
    en_req = 0;
    chk("R2", "clk_en first edge", int'(trk_clk_en), 1);
    chk("R2", "busy first edge", int'(busy), 1);
    chk("R2", "count first edge", int'(use_count), 1);
    chk("R2", "timer not yet", int'(start_timer), 0);
    chk("R2", "bias_pd first edge", int'(bias_pd), 1);
    @(negedge clk);
    chk("R2", "start_timer", int'(start_timer), 30);
    chk("R2", "done_timer", int'(done_timer), 10);
    chk("R2", "bias_pd second edge", int'(bias_pd), 1);
    @(negedge clk);
    chk("R2", "bias_pd released", int'(bias_pd), 0);
    chk("R2", "squelch captured", int'(squelch_lvl), 5);
    chk("R2", "trk_pd still set", int'(trk_pd), 1);
    k = 0;
    while (trk_pd && k < 2000) begin
      @(negedge clk);
      k++;
      if (trk_pd) chk("R3", "busy during settle", int'(busy), 1);
    end
    chk("R3", "settle cycles", k, SETTLE);
    chk("R3", "busy after settle", int'(busy), 0);
    m_cnt = 1; m_bias_on = 1; m_sq = 5;

    // R10 squelch not re-sampled
    squelch_in = 3'd2;
    step(1, 0, "R10");
    chk("R10", "squelch kept", int'(squelch_lvl), 5);

    // R4 increments and saturation
    step(1, 0, "R4");
    step(1, 0, "R4");
    chk("R4", "saturated", int'(use_count), 3);

    // R9 simultaneous
    step(1, 1, "R9");

    // R5 decrements
    step(0, 1, "R5");
    step(0, 1, "R5");
    chk("R5", "count after two drops", int'(use_count), 1);

    // R6 detailed power-down
    dis_req = 1;
    @(negedge clk);
    dis_req = 0;
    chk("R6", "trk_pd set", int'(trk_pd), 1);
    chk("R6", "clk still on", int'(trk_clk_en), 1);
    chk("R6", "busy", int'(busy), 1);
    chk("R6", "count", int'(use_count), 0);
    @(negedge clk);
    chk("R6", "clk off", int'(trk_clk_en), 0);
    chk("R6", "busy cleared", int'(busy), 0);
    chk("R6", "bias_pd unchanged", int'(bias_pd), 0);
    m_cnt = 0;

    // R7 underflow
    step(0, 1, "R7");
    chk("R7", "count stays zero", int'(use_count), 0);

    // R8 requests during busy
    en_req = 1;
    @(negedge clk);
    chk("R8", "busy started", int'(busy), 1);
    en_req = 1;
    @(negedge clk);
    en_req = 0; dis_req = 1;
    @(negedge clk);
    dis_req = 0;
    while (busy) @(negedge clk);
    chk("R8", "count after busy requests", int'(use_count), 1);
    m_cnt = 1; m_sq = 2;
    step(0, 1, "R8");

    // Sweep: all counts, all request kinds, all squelch settings
    for (int s = 0; s < 8; s++) begin
      squelch_in = 3'(s);
      for (int i = 0; i < 24; i++) begin
        int op = (i * 7 + s + i / 5) % 3;
        step(op == 0 || op == 2, op == 1 || op == 2, "R4_R5_R2");
      end
      while (m_cnt > 0) step(0, 1, "R6");
      step(1, 0, "R10");
      chk("R10", "sweep squelch", int'(squelch_lvl), s);
      step(0, 1, "R6");
    end

    summary();
  end
endmodule